// File: doc/BRIEF.md
# Oversampled Serial Receiver with Three-Entry Queue

This block is the receive half of an asynchronous serial port. It watches a single idle-high line, finds each start bit, and recovers a frame of eight data bits sent least significant bit first. The frame may carry a ninth bit, and it ends with one stop bit. The line is timed by an enable strobe that the surrounding logic supplies at sixteen times the bit rate. Frames that end with a good stop bit are placed in a small first-in first-out queue. The host drains the queue one word per read strobe.

Two status outputs report the queue. A ready flag rises when a word is stored. An overrun flag is sticky and latches whenever a finished frame finds the queue full. In multiprocessor mode the ninth bit is always present, and only frames whose ninth bit is 1 raise the ready flag. Nodes on a shared line use this to wake only on address frames while data frames still fill the queue.

Top module: `serial_rx_queue`

## Requirements
- R1: While `rx_en` is 0 the receiver stays idle. Nothing that appears on `rxd` is stored or affects any flag.
- R2: A frame is a low start bit, then 8 data bits sent LSB first, then an extra bit when `xbit_en` or `mp_mode` is 1, then a stop bit. Each bit lasts 16 strobes of `tick16` and is sampled near its centre.
- R3: A low level on the line is accepted as a start bit only if the line is still low at mid-start, 8 strobes after the falling edge is seen. A shorter low pulse is ignored, and the receiver is ready for the next falling edge.
- R4: A finished frame is stored only when the stop bit is 1 and the queue is not full. The queue holds at most 3 words.
- R5: A frame with a good stop bit that finishes while the queue holds 3 words is discarded and sets `overrun`. `overrun` stays 1 through reads and clears only on an `ovr_clr` pulse. If a set and a clear fall in the same cycle, the set wins.
- R6: A frame whose stop bit is sampled as 0 is not stored and does not change `ready` or `overrun`.
- R7: Storing a word sets `ready`. When `mp_mode` is 1, `ready` is set only if the stored extra bit is 1.
- R8: A one-cycle `rd_en` pulse while the queue is not empty removes the oldest word. On the next cycle `rd_data` holds that word's data and `rd_xbit` holds its extra bit (0 for a frame without one). Words leave in arrival order.
- R9: `ready` stays 1 after a read while words remain in the queue. It falls to 0 on the read that empties the queue.
- R10: A read while the queue is empty leaves `rd_data` and `rd_xbit` at the last word read and does not change the queue contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit time |
| rx_en | input | 1 | Receive enable |
| xbit_en | input | 1 | Frames carry an extra ninth bit |
| mp_mode | input | 1 | Multiprocessor mode (implies extra bit) |
| rxd | input | 1 | Serial line, idle high |
| rd_en | input | 1 | Pop the oldest queued word |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Data of the last word popped |
| rd_xbit | output | 1 | Extra bit of the last word popped |
| ready | output | 1 | Words available (qualified in multiprocessor mode) |
| overrun | output | 1 | Sticky overflow flag |

## Verification
The bench uses the default parameters: 8 data bits, a 3-word queue and 16 strobes per bit. It raises `tick16` on every second clock, so each bit lasts 32 clocks and the strobe gating is exercised, not bypassed. With a queue of only 3 words, four frames in a row fill it and then overflow it. The bench then drains it past empty, which covers the sticky overrun flag, the ready flag falling on the last read, and the hold-on-empty read. A 16-strobe bit gives a mid-start check at 8 strobes, which a 3-strobe low pulse fails, and a whole frame fits in a few hundred clocks.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    SRX_IDLE,
    SRX_START,
    SRX_DATA,
    SRX_XBIT,
    SRX_STOP
  } srx_state_e;

  // ready qualification: in multiprocessor mode only extra-bit=1 frames wake the host
  function automatic logic srx_wake(input logic mp, input logic xb);
    return (!mp) | xb;
  endfunction

  // strobe index at which the start bit is re-checked
  function automatic int srx_mid_index(input int osr);
    return (osr / 2) - 1;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              xbit_en,
  input  logic              rxd,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_xbit,
  output logic              frame_stop_ok,
  output logic              busy
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID_C   = CW'(srx_mid_index(OSR));
  localparam logic [CW-1:0] LAST_C  = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(DATA_W - 1);

  srx_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bitn_q;
  logic [DATA_W-1:0] shreg_q;
  logic              xbit_q;
  logic              stop_q;
  logic              done_q;
  logic              at_mid;
  logic              at_end;

  assign at_mid = (cnt_q == MID_C);
  assign at_end = (cnt_q == LAST_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SRX_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      xbit_q  <= 1'b0;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!rx_en) begin
        state_q <= SRX_IDLE;
      end else if (tick) begin
        case (state_q)
          SRX_IDLE: begin
            if (!rxd) begin
              state_q <= SRX_START;
              cnt_q   <= '0;
            end
          end
          SRX_START: begin
            if (at_mid) begin
              if (!rxd) begin
                state_q <= SRX_DATA;
                cnt_q   <= '0;
                bitn_q  <= '0;
                xbit_q  <= 1'b0;
              end else begin
                state_q <= SRX_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          SRX_DATA: begin
            if (at_end) begin
              cnt_q   <= '0;
              shreg_q <= {rxd, shreg_q[DATA_W-1:1]};
              if (bitn_q == LASTBIT) state_q <= xbit_en ? SRX_XBIT : SRX_STOP;
              else                   bitn_q  <= bitn_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          SRX_XBIT: begin
            if (at_end) begin
              cnt_q   <= '0;
              xbit_q  <= rxd;
              state_q <= SRX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          SRX_STOP: begin
            if (at_end) begin
              cnt_q   <= '0;
              stop_q  <= rxd;
              done_q  <= 1'b1;
              state_q <= SRX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= SRX_IDLE;
        endcase
      end
    end
  end

  assign frame_done    = done_q;
  assign frame_data    = shreg_q;
  assign frame_xbit    = xbit_q;
  assign frame_stop_ok = stop_q;
  assign busy          = (state_q != SRX_IDLE);

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !busy);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [PW-1:0]   wp_q, rp_q;
  logic [CNTW-1:0] cnt_q;
  logic            do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign do_push = push & !full;
  assign do_pop  = pop & !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= ptr_next(wp_q);
      if (do_pop)  rp_q <= ptr_next(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wdata;
  end

  assign head  = mem_q[rp_q];
  assign count = cnt_q;

  // R4
  cnt_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(DEPTH));

  // R8
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 3,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_en,
  input  logic              xbit_en,
  input  logic              mp_mode,
  input  logic              rxd,
  input  logic              rd_en,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_xbit,
  output logic              ready,
  output logic              overrun
);
  localparam int WW   = DATA_W + 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic              rxd_s;
  logic              frame_done, frame_xbit, frame_stop_ok, rx_busy;
  logic [DATA_W-1:0] frame_data;
  logic [WW-1:0]     fifo_head;
  logic              fifo_empty, fifo_full;
  logic [CNTW-1:0]   fifo_count;
  logic              push_try, push_ok, ovr_ev, pop_ok, last_pop;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_xbit_q, ready_q, ovr_q;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  srx_deframer #(.DATA_W(DATA_W), .OSR(OSR)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_en(rx_en),
    .xbit_en(xbit_en | mp_mode), .rxd(rxd_s),
    .frame_done(frame_done), .frame_data(frame_data),
    .frame_xbit(frame_xbit), .frame_stop_ok(frame_stop_ok), .busy(rx_busy)
  );

  assign push_try = frame_done & frame_stop_ok;
  assign push_ok  = push_try & !fifo_full;
  assign ovr_ev   = push_try & fifo_full;
  assign pop_ok   = rd_en & !fifo_empty;
  assign last_pop = pop_ok & (fifo_count == CNTW'(1)) & !push_ok;

  srx_fifo #(.W(WW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .wdata({frame_xbit, frame_data}),
    .pop(rd_en), .head(fifo_head), .empty(fifo_empty), .full(fifo_full),
    .count(fifo_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      rd_xbit_q <= 1'b0;
      ready_q   <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (pop_ok) begin
        rd_data_q <= fifo_head[DATA_W-1:0];
        rd_xbit_q <= fifo_head[DATA_W];
      end
      if (push_ok && srx_wake(mp_mode, frame_xbit)) ready_q <= 1'b1;
      else if (last_pop)                            ready_q <= 1'b0;
      if (ovr_ev)       ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
    end
  end

  assign rd_data = rd_data_q;
  assign rd_xbit = rd_xbit_q;
  assign ready   = ready_q;
  assign overrun = ovr_q;

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_stop_ok && fifo_full) |=> overrun);

  // R6
  bad_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_stop_ok && !rd_en) |=> $stable(fifo_count));

  // R7
  mp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_mode && frame_done && !frame_xbit && !ready && !rd_en) |=> !ready);

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> fifo_empty);

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_empty) |=> ($stable(rd_data) && $stable(rd_xbit)));

  // R1
  off_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !frame_done);
endmodule

// File: tb/serial_rx_queue_tb.sv
module serial_rx_queue_tb;
  localparam int TDIV   = 2;
  localparam int OSR    = 16;
  localparam int BITCLK = OSR * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_en = 1'b0, xbit_en = 1'b0, mp_mode = 1'b0;
  logic       rxd = 1'b1, rd_en = 1'b0, ovr_clr = 1'b0;
  logic [7:0] rd_data;
  logic       rd_xbit, ready, overrun;
  int         tests = 0, fails = 0;
  bit         done = 1'b0;
  int         tdiv_cnt = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    tick16   <= (tdiv_cnt == 0);
  end

  serial_rx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en),
    .xbit_en(xbit_en), .mp_mode(mp_mode), .rxd(rxd), .rd_en(rd_en),
    .ovr_clr(ovr_clr), .rd_data(rd_data), .rd_xbit(rd_xbit),
    .ready(ready), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit wake(input bit mp, input bit xb);
    return mp ? xb : 1'b1;
  endfunction

  task automatic send(input logic [7:0] d, input bit with_x, input bit xb, input bit stopv);
    @(negedge clk);
    rxd = 1'b0; repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; repeat (BITCLK) @(negedge clk);
    end
    if (with_x) begin
      rxd = xb; repeat (BITCLK) @(negedge clk);
    end
    rxd = stopv; repeat (BITCLK) @(negedge clk);
    rxd = 1'b1; repeat (2 * BITCLK) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(ready == 1'b0, "R7 reset ready", ready, 0);
    chk(overrun == 1'b0, "R5 reset overrun", overrun, 0);
    chk(rd_data == 8'h00, "R8 reset rd_data", rd_data, 0);
  endtask

  task automatic t_basic();
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    chk(ready == wake(1'b0, 1'b0), "R7 ready after store", ready, 1);
    do_read();
    chk(rd_data == 8'hA5, "R2 R8 data", rd_data, 8'hA5);
    chk(rd_xbit == 1'b0, "R8 xbit without extra", rd_xbit, 0);
    chk(ready == 1'b0, "R9 ready drops when empty", ready, 0);
  endtask

  task automatic t_fill_overrun();
    send(8'h11, 1'b0, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b0, 1'b1);
    send(8'h33, 1'b0, 1'b0, 1'b1);
    chk(overrun == 1'b0, "R4 three words fit", overrun, 0);
    send(8'h44, 1'b0, 1'b0, 1'b1);
    chk(overrun == 1'b1, "R5 overrun on full", overrun, 1);
    do_read();
    chk(rd_data == 8'h11, "R8 oldest first", rd_data, 8'h11);
    chk(ready == 1'b1, "R9 ready held while non-empty", ready, 1);
    do_read();
    chk(rd_data == 8'h22, "R8 second", rd_data, 8'h22);
    do_read();
    chk(rd_data == 8'h33, "R4 R8 third, fourth dropped", rd_data, 8'h33);
    chk(ready == 1'b0, "R9 ready drops on last read", ready, 0);
    chk(overrun == 1'b1, "R5 overrun sticky across reads", overrun, 1);
    do_read();
    chk(rd_data == 8'h33, "R10 empty read holds data", rd_data, 8'h33);
    chk(ready == 1'b0, "R10 empty read keeps ready low", ready, 0);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk(overrun == 1'b0, "R5 clear", overrun, 0);
  endtask

  task automatic t_bad_stop();
    send(8'h5A, 1'b0, 1'b0, 1'b0);
    chk(ready == 1'b0, "R6 bad stop no ready", ready, 0);
    chk(overrun == 1'b0, "R6 bad stop no overrun", overrun, 0);
    do_read();
    chk(rd_data == 8'h33, "R6 bad stop not stored", rd_data, 8'h33);
    send(8'h3C, 1'b0, 1'b0, 1'b1);
    do_read();
    chk(rd_data == 8'h3C, "R6 next frame after bad stop", rd_data, 8'h3C);
  endtask

  task automatic t_glitch();
    @(negedge clk); rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    chk(ready == 1'b0, "R3 glitch ignored", ready, 0);
    do_read();
    chk(rd_data == 8'h3C, "R3 glitch stored nothing", rd_data, 8'h3C);
    send(8'h81, 1'b0, 1'b0, 1'b1);
    do_read();
    chk(rd_data == 8'h81, "R3 frame after glitch", rd_data, 8'h81);
  endtask

  task automatic t_rx_off();
    rx_en = 1'b0;
    send(8'h77, 1'b0, 1'b0, 1'b1);
    chk(ready == 1'b0, "R1 disabled no ready", ready, 0);
    do_read();
    chk(rd_data == 8'h81, "R1 disabled nothing stored", rd_data, 8'h81);
    rx_en = 1'b1;
  endtask

  task automatic t_extra_bit();
    xbit_en = 1'b1;
    send(8'h0F, 1'b1, 1'b1, 1'b1);
    do_read();
    chk(rd_data == 8'h0F, "R2 data with extra bit", rd_data, 8'h0F);
    chk(rd_xbit == 1'b1, "R2 R8 extra bit", rd_xbit, 1);
    xbit_en = 1'b0;
  endtask

  task automatic t_mp();
    mp_mode = 1'b1;
    send(8'h12, 1'b1, 1'b0, 1'b1);
    chk(ready == wake(1'b1, 1'b0), "R7 mp data frame quiet", ready, 0);
    send(8'h34, 1'b1, 1'b1, 1'b1);
    chk(ready == wake(1'b1, 1'b1), "R7 mp address frame wakes", ready, 1);
    do_read();
    chk(rd_data == 8'h12 && rd_xbit == 1'b0, "R7 R8 mp first word", {rd_xbit, rd_data}, 9'h012);
    do_read();
    chk(rd_data == 8'h34 && rd_xbit == 1'b1, "R7 R8 mp second word", {rd_xbit, rd_data}, 9'h134);
    chk(ready == 1'b0, "R9 mp ready cleared", ready, 0);
    mp_mode = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    t_basic();
    t_fill_overrun();
    t_bad_stop();
    t_glitch();
    t_rx_off();
    t_extra_bit();
    t_mp();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule